// File: doc/BRIEF.md
# Verified SPI Memory Writer

This block copies a byte buffer from a small local RAM into a serial EEPROM or flash and proves each piece landed correctly. It works through an existing SPI command engine over a request/acknowledge port. For every piece it sends a write-enable, then the data write. It then polls the part's status byte at a fixed interval until the part reports idle. Last, it reads the same bytes back and compares them with the buffer. A piece never crosses the part's write-block boundary and never exceeds 16 bytes.

The same block can also fill its local RAM from the part. In that mode it issues plain reads in pieces of up to 16 bytes and ignores block boundaries. Small 512-byte parts that use a one-byte address carry address bit 8 inside the instruction byte, and the block folds that bit in on its own. When it finishes, the block pulses `done` once. It then holds the number of bytes fully completed and an error code until the next start.

Top module: `nvm_verify_writer`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_req` are 0, `err_code` is 0 and `done_count` is 0.
- R2: In write mode each piece is issued as four kinds of command in this order. First is write-enable (opcode 0x06, no address, length 0). Next is data write (0x02, addressed). Then come one or more status reads (0x05, no address, length 1). Last is a data read (0x03, addressed) of the same address and length.
- R3: A write piece is the smallest of three values: the bytes remaining, 16, and B minus (piece address mod B), with B = 2^`cfg_blk_log2` (values above 8 count as 8).
- R4: In read mode each piece is min(remaining, 16), block boundaries are ignored, and no write-enable or status read is issued. The returned bytes are stored in the local RAM at the buffer offset of that piece, and `buf_rdata` shows them.
- R5: The first status read after a data write, and each further one, starts POLL_CYCLES clock cycles after the previous command is acknowledged. Status bit 0 = 1 means busy, and bit 0 = 0 lets the read-back start.
- R6: If MAX_POLLS status reads in a row all return bit 0 = 1, the operation ends with `err_code` = 1 (timeout). `done_count` then gives the bytes of earlier pieces only, and no data read follows.
- R7: If any read-back byte differs from the buffer, the operation ends with `err_code` = 2 (verify). `done_count` leaves out that piece, and no further command is issued.
- R8: When `cfg_size_log2` = 9 and `cfg_addr_bytes` = 1, opcodes 0x02 and 0x03 carry address bit 8 in opcode bit 3 (0x0A / 0x0B). Otherwise opcode bit 3 is 0.
- R9: `cmd_addr` carries only the low `cfg_addr_bytes` bytes of the piece address, with the higher bytes zero. Write-enable and status read give `cmd_addr_bytes` = 0.
- R10: `done` is high for exactly one cycle per operation. `err_code` and `done_count` stay unchanged until the next accepted start, and a `start` while `busy` is ignored.
- R11: A start with `xfer_len` = 0 ends with `done`, `err_code` = 0 and `done_count` = 0, and no command is issued.
- R12: While `cmd_req` is high and not yet acknowledged, the opcode, address and length do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| op_read | input | 1 | 1 = fill buffer from part, 0 = verified write |
| start_addr | input | 24 | First part address |
| xfer_len | input | 7 | Bytes to move (clamped to buffer depth) |
| cfg_addr_bytes | input | 2 | Address bytes the part expects (1 to 3) |
| cfg_size_log2 | input | 5 | log2 of part size in bytes |
| cfg_blk_log2 | input | 4 | log2 of write-block size (3 to 8) |
| buf_we | input | 1 | Host write strobe into local RAM |
| buf_addr | input | 6 | Host RAM byte address |
| buf_wdata | input | 8 | Host write byte |
| buf_rdata | output | 8 | RAM byte at `buf_addr` |
| cmd_req | output | 1 | Command request to SPI engine |
| cmd_opcode | output | 8 | Instruction byte |
| cmd_addr | output | 24 | Masked address |
| cmd_addr_bytes | output | 2 | Address bytes to send (0 = none) |
| cmd_len | output | 5 | Data bytes (0 to 16) |
| cmd_rd | output | 1 | 1 = data phase is a read |
| cmd_wdata | output | 128 | Write bytes, byte 0 in bits 7:0 |
| cmd_ack | input | 1 | One-cycle completion from engine |
| cmd_rdata | input | 128 | Read bytes, valid with `cmd_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 verify mismatch |
| done_count | output | 7 | Bytes completed |

## Verification
The embedded properties cover the checks that apply on every cycle. They confirm that command fields stay frozen until acknowledged and that no write piece crosses its block. They confirm that status commands and write-enable carry no address, that opcode bit 3 stays clear outside the 9-bit address mode, and that read mode never issues write-enable. They also confirm that the poll counter stays below its limit and that results hold between operations. Some behaviour only shows up in the directed scenarios against a model of the part: the exact split of a transfer into pieces, the command order for each piece, the spacing of status reads, and where data lands in the part and the buffer. The timeout and mismatch endings, with their byte counts, also need those scenarios.

// File: rtl/nvwv_pkg.sv
package nvwv_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_RDSR  = 8'h05;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_VERIFY  = 2'd2
  } err_e;

  typedef enum logic [1:0] {
    K_WREN,
    K_WRITE,
    K_RDSR,
    K_READ
  } cmd_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CALC,
    S_WREN,
    S_WRITE,
    S_PWAIT,
    S_POLL,
    S_RDBK,
    S_FIN
  } state_e;
endpackage

// File: rtl/nvwv_chunk_calc.sv
module nvwv_chunk_calc #(
  parameter int CNT_W        = 7,
  parameter int LEN_W        = 5,
  parameter int CHUNK_MAX    = 16,
  parameter int MAX_BLK_LOG2 = 8
) (
  input  logic [MAX_BLK_LOG2-1:0] addr_lo,
  input  logic [CNT_W-1:0]        remaining,
  input  logic [3:0]              blk_log2,
  input  logic                    bound_en,
  output logic [LEN_W-1:0]        chunk_len
);
  localparam int BW = MAX_BLK_LOG2 + 1;

  logic [3:0]       blk_eff;
  logic [BW-1:0]    blk_size;
  logic [BW-1:0]    offs;
  logic [BW-1:0]    room;
  logic [CNT_W-1:0] capped;

  always_comb begin
    blk_eff  = (blk_log2 > 4'(MAX_BLK_LOG2)) ? 4'(MAX_BLK_LOG2) : blk_log2;
    blk_size = BW'(1) << blk_eff;
    offs     = {1'b0, addr_lo} & (blk_size - BW'(1));
    room     = blk_size - offs;
    capped   = (remaining > CNT_W'(CHUNK_MAX)) ? CNT_W'(CHUNK_MAX) : remaining;
    chunk_len = LEN_W'(capped);
    if (bound_en && (16'(room) < 16'(capped)))
      chunk_len = LEN_W'(room);
  end
endmodule

// File: rtl/nvwv_cmd_fmt.sv
module nvwv_cmd_fmt
  import nvwv_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  cmd_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        addr_bytes,
  input  logic              munge_en,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        addr_bytes_out
);
  localparam int NBYTES = ADDR_W / 8;

  logic carries_addr;
  logic [7:0] base_op;

  always_comb begin
    unique case (kind)
      K_WREN:  base_op = OPC_WREN;
      K_WRITE: base_op = OPC_WRITE;
      K_RDSR:  base_op = OPC_RDSR;
      default: base_op = OPC_READ;
    endcase
    carries_addr = (kind == K_WRITE) || (kind == K_READ);
    opcode = base_op;
    if (carries_addr && munge_en && addr[8])
      opcode = base_op | 8'h08;
    addr_out = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (carries_addr && (b < int'(addr_bytes)))
        addr_out[b*8 +: 8] = addr[b*8 +: 8];
    end
    addr_bytes_out = carries_addr ? addr_bytes : 2'd0;
  end
endmodule

// File: rtl/nvwv_buf.sv
module nvwv_buf #(
  parameter int DEPTH = 64,
  parameter int WIN   = 16,
  parameter int AW    = 6,
  parameter int PW    = 7,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [PW-1:0]    win_ptr,
  output logic [WIN*8-1:0] win_data,
  input  logic             fill_en,
  input  logic [LEN_W-1:0] fill_len,
  input  logic [WIN*8-1:0] fill_data
);
  localparam int WSEL = $clog2(WIN);

  logic [DEPTH*8-1:0] mem_flat;

  for (genvar j = 0; j < DEPTH; j++) begin : g_cell
    logic [7:0]    cell_q;
    logic [PW-1:0] rel;
    logic          in_fill;
    logic          host_hit;

    always_comb begin
      rel      = PW'(j) - win_ptr;
      in_fill  = fill_en && (PW'(j) >= win_ptr) && (rel < PW'(fill_len));
      host_hit = host_we && (host_addr == AW'(j));
    end

    always_ff @(posedge clk) begin
      if (in_fill)
        cell_q <= fill_data[rel[WSEL-1:0]*8 +: 8];
      else if (host_hit)
        cell_q <= host_wdata;
    end

    assign mem_flat[j*8 +: 8] = cell_q;
  end

  assign host_rdata = mem_flat[host_addr*8 +: 8];

  for (genvar i = 0; i < WIN; i++) begin : g_win
    logic [PW:0] idx;
    always_comb begin
      idx = {1'b0, win_ptr} + (PW+1)'(i);
      win_data[i*8 +: 8] = (idx < (PW+1)'(DEPTH)) ? mem_flat[idx[AW-1:0]*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/nvwv_poll_timer.sv
module nvwv_poll_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    expired = armed_q && (cnt_q == '0);
    if (load) begin
      cnt_d   = TW'(CYCLES - 1);
      armed_d = 1'b1;
    end else if (expired) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(CYCLES - 1)) else $error("timer count out of range"); // R5
endmodule

// File: rtl/nvm_verify_writer.sv
module nvm_verify_writer
  import nvwv_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int BUF_DEPTH    = 64,
  parameter int CHUNK_MAX    = 16,
  parameter int MAX_BLK_LOG2 = 8,
  parameter int POLL_CYCLES  = 1000,
  parameter int MAX_POLLS    = 50
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           op_read,
  input  logic [ADDR_W-1:0]              start_addr,
  input  logic [$clog2(BUF_DEPTH+1)-1:0] xfer_len,
  input  logic [1:0]                     cfg_addr_bytes,
  input  logic [4:0]                     cfg_size_log2,
  input  logic [3:0]                     cfg_blk_log2,
  input  logic                           buf_we,
  input  logic [$clog2(BUF_DEPTH)-1:0]   buf_addr,
  input  logic [7:0]                     buf_wdata,
  output logic [7:0]                     buf_rdata,
  output logic                           cmd_req,
  output logic [7:0]                     cmd_opcode,
  output logic [ADDR_W-1:0]              cmd_addr,
  output logic [1:0]                     cmd_addr_bytes,
  output logic [$clog2(CHUNK_MAX+1)-1:0] cmd_len,
  output logic                           cmd_rd,
  output logic [CHUNK_MAX*8-1:0]         cmd_wdata,
  input  logic                           cmd_ack,
  input  logic [CHUNK_MAX*8-1:0]         cmd_rdata,
  output logic                           busy,
  output logic                           done,
  output logic [1:0]                     err_code,
  output logic [$clog2(BUF_DEPTH+1)-1:0] done_count
);
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
  localparam int AW     = $clog2(BUF_DEPTH);
  localparam int LEN_W  = $clog2(CHUNK_MAX + 1);
  localparam int WIN_W  = CHUNK_MAX * 8;
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int BW     = MAX_BLK_LOG2 + 1;

  state_e            state_q, state_d;
  logic [CNT_W-1:0]  pos_q, pos_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              rd_q, rd_d;
  logic [1:0]        ab_q, ab_d;
  logic              munge_q, munge_d;
  logic [3:0]        blk_q, blk_d;
  logic [LEN_W-1:0]  chunk_q, chunk_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  err_e              err_q, err_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [ADDR_W-1:0] piece_addr;
  logic [LEN_W-1:0]  calc_len;
  logic [WIN_W-1:0]  win_data;
  logic              timer_load, timer_exp;
  logic              fill_en;
  logic              mismatch;
  cmd_kind_e         kind;

  assign piece_addr = base_q + ADDR_W'(pos_q);

  nvwv_chunk_calc #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX), .MAX_BLK_LOG2(MAX_BLK_LOG2)
  ) u_calc (
    .addr_lo   (piece_addr[MAX_BLK_LOG2-1:0]),
    .remaining (len_q - pos_q),
    .blk_log2  (blk_q),
    .bound_en  (!rd_q),
    .chunk_len (calc_len)
  );

  nvwv_buf #(
    .DEPTH(BUF_DEPTH), .WIN(CHUNK_MAX), .AW(AW), .PW(CNT_W), .LEN_W(LEN_W)
  ) u_buf (
    .clk        (clk),
    .host_we    (buf_we),
    .host_addr  (buf_addr),
    .host_wdata (buf_wdata),
    .host_rdata (buf_rdata),
    .win_ptr    (pos_q),
    .win_data   (win_data),
    .fill_en    (fill_en),
    .fill_len   (chunk_q),
    .fill_data  (cmd_rdata)
  );

  nvwv_poll_timer #(.CYCLES(POLL_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .expired (timer_exp)
  );

  always_comb begin
    unique case (state_q)
      S_WREN:  kind = K_WREN;
      S_WRITE: kind = K_WRITE;
      S_POLL:  kind = K_RDSR;
      default: kind = K_READ;
    endcase
  end

  nvwv_cmd_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .kind           (kind),
    .addr           (piece_addr),
    .addr_bytes     (ab_q),
    .munge_en       (munge_q),
    .opcode         (cmd_opcode),
    .addr_out       (cmd_addr),
    .addr_bytes_out (cmd_addr_bytes)
  );

  always_comb begin
    cmd_req   = (state_q == S_WREN) || (state_q == S_WRITE) ||
                (state_q == S_POLL) || (state_q == S_RDBK);
    cmd_rd    = (state_q == S_POLL) || (state_q == S_RDBK);
    cmd_wdata = (state_q == S_WRITE) ? win_data : '0;
    unique case (state_q)
      S_POLL:          cmd_len = LEN_W'(1);
      S_WRITE, S_RDBK: cmd_len = chunk_q;
      default:         cmd_len = '0;
    endcase
  end

  always_comb begin
    mismatch = 1'b0;
    for (int i = 0; i < CHUNK_MAX; i++) begin
      if ((LEN_W'(i) < chunk_q) && (cmd_rdata[i*8 +: 8] != win_data[i*8 +: 8]))
        mismatch = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;  pos_d = pos_q;   len_d = len_q;   base_d = base_q;
    rd_d    = rd_q;     ab_d  = ab_q;    munge_d = munge_q; blk_d = blk_q;
    chunk_d = chunk_q;  poll_d = poll_q; err_d = err_q;   cnt_d = cnt_q;
    timer_load = 1'b0;
    fill_en    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        len_d   = (xfer_len > CNT_W'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH) : xfer_len;
        base_d  = start_addr;
        rd_d    = op_read;
        ab_d    = cfg_addr_bytes;
        munge_d = (cfg_size_log2 == 5'd9) && (cfg_addr_bytes == 2'd1);
        blk_d   = cfg_blk_log2;
        pos_d   = '0;
        err_d   = ERR_NONE;
        cnt_d   = '0;
        state_d = S_CALC;
      end
      S_CALC: begin
        if (pos_q == len_q) begin
          state_d = S_FIN;
        end else begin
          chunk_d = calc_len;
          poll_d  = '0;
          state_d = rd_q ? S_RDBK : S_WREN;
        end
      end
      S_WREN:  if (cmd_ack) state_d = S_WRITE;
      S_WRITE: if (cmd_ack) begin
        timer_load = 1'b1;
        state_d    = S_PWAIT;
      end
      S_PWAIT: if (timer_exp) state_d = S_POLL;
      S_POLL: if (cmd_ack) begin
        if (!cmd_rdata[0]) begin
          state_d = S_RDBK;
        end else if (poll_q == POLL_W'(MAX_POLLS - 1)) begin
          err_d   = ERR_TIMEOUT;
          state_d = S_FIN;
        end else begin
          poll_d     = poll_q + POLL_W'(1);
          timer_load = 1'b1;
          state_d    = S_PWAIT;
        end
      end
      S_RDBK: if (cmd_ack) begin
        if (rd_q) begin
          fill_en = 1'b1;
          pos_d   = pos_q + CNT_W'(chunk_q);
          state_d = S_CALC;
        end else if (mismatch) begin
          err_d   = ERR_VERIFY;
          state_d = S_FIN;
        end else begin
          pos_d   = pos_q + CNT_W'(chunk_q);
          state_d = S_CALC;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if ((state_d == S_FIN) && (state_q != S_FIN))
      cnt_d = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
      rd_q    <= 1'b0;
      ab_q    <= '0;
      munge_q <= 1'b0;
      blk_q   <= '0;
      chunk_q <= '0;
      poll_q  <= '0;
      err_q   <= ERR_NONE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
      base_q  <= base_d;
      rd_q    <= rd_d;
      ab_q    <= ab_d;
      munge_q <= munge_d;
      blk_q   <= blk_d;
      chunk_q <= chunk_d;
      poll_q  <= poll_d;
      err_q   <= err_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_FIN);
  assign err_code   = err_q;
  assign done_count = cnt_q;

  logic [3:0]    a_blk_eff;
  logic [BW-1:0] a_blk_size;
  logic [15:0]   a_end;
  always_comb begin
    a_blk_eff  = (blk_q > 4'(MAX_BLK_LOG2)) ? 4'(MAX_BLK_LOG2) : blk_q;
    a_blk_size = BW'(1) << a_blk_eff;
    a_end      = 16'(cmd_addr[MAX_BLK_LOG2-1:0] & (a_blk_size[MAX_BLK_LOG2-1:0] - 1'b1))
                 + 16'(cmd_len);
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_opcode) && $stable(cmd_addr) && $stable(cmd_len))
    else $error("command changed before ack"); // R12
  AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && (cmd_opcode[7:4] == 4'h0) && (cmd_opcode[2:0] == 3'h2) && !munge_q
    |-> (cmd_len != '0) && (cmd_len <= LEN_W'(CHUNK_MAX)) && (a_end <= 16'(a_blk_size)))
    else $error("write piece crosses block"); // R3
  AST_STATUS_NOADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && ((cmd_opcode == OPC_WREN) || (cmd_opcode == OPC_RDSR)) |-> (cmd_addr_bytes == 2'd0))
    else $error("status command carries address"); // R9
  AST_MUNGE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !munge_q |-> !cmd_opcode[3])
    else $error("opcode bit 3 set outside munge mode"); // R8
  AST_READ_NO_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && rd_q |-> (cmd_opcode != OPC_WREN) && (cmd_opcode != OPC_RDSR))
    else $error("read mode issued write-enable or poll"); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(err_code) && $stable(done_count))
    else $error("result changed while idle"); // R10
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < POLL_W'(MAX_POLLS)) else $error("poll count overflow"); // R6
endmodule

// File: tb/tb_nvm_verify_writer.sv
`timescale 1ns/1ps
module tb_nvm_verify_writer;
  localparam int PC = 16;

  logic         clk, rst_n, start, op_read;
  logic [23:0]  start_addr;
  logic [6:0]   xfer_len;
  logic [1:0]   cfg_addr_bytes;
  logic [4:0]   cfg_size_log2;
  logic [3:0]   cfg_blk_log2;
  logic         buf_we;
  logic [5:0]   buf_addr;
  logic [7:0]   buf_wdata, buf_rdata;
  logic         cmd_req, cmd_rd, cmd_ack;
  logic [7:0]   cmd_opcode;
  logic [23:0]  cmd_addr;
  logic [1:0]   cmd_addr_bytes;
  logic [4:0]   cmd_len;
  logic [127:0] cmd_wdata, cmd_rdata;
  logic         busy, done;
  logic [1:0]   err_code;
  logic [6:0]   done_count;

  nvm_verify_writer #(.POLL_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read), .start_addr(start_addr),
    .xfer_len(xfer_len), .cfg_addr_bytes(cfg_addr_bytes), .cfg_size_log2(cfg_size_log2),
    .cfg_blk_log2(cfg_blk_log2), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_len(cmd_len), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
    .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .busy(busy), .done(done), .err_code(err_code),
    .done_count(done_count));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int log_op[256], log_addr[256], log_len[256], log_ab[256], log_cyc[256];
  int log_n = 0;
  logic [7:0] dev_mem [1024];
  int busy_polls_cfg = 0, busy_left = 0, stuck_write_n = 0, write_n = 0;
  int corrupt_read_n = 0, read_n = 0, wr_ack_cyc = 0;
  bit stuck = 0, model_munge = 0;
  int res_err, res_cnt;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // SPI part model with command log
  initial begin
    cmd_ack = 1'b0;
    cmd_rdata = '0;
    forever begin
      @(negedge clk);
      if (cmd_req === 1'b1) begin
        logic [7:0]   op, bop;
        int           fa, ln;
        logic [127:0] rd;
        op = cmd_opcode; ln = int'(cmd_len);
        fa = int'(cmd_addr);
        if (model_munge && op[3]) fa = fa | 256;
        bop = op & 8'hF7;
        if (log_n < 256) begin
          log_op[log_n] = int'(op); log_addr[log_n] = int'(cmd_addr);
          log_len[log_n] = ln; log_ab[log_n] = int'(cmd_addr_bytes); log_cyc[log_n] = cyc;
          log_n++;
        end
        rd = '0;
        if (bop == 8'h02) begin
          write_n++;
          if (write_n == stuck_write_n) stuck = 1;
          for (int i = 0; i < ln; i++) dev_mem[(fa + i) % 1024] = cmd_wdata[i*8 +: 8];
          busy_left = busy_polls_cfg;
        end else if (bop == 8'h05) begin
          rd[0] = stuck || (busy_left > 0);
          if (busy_left > 0) busy_left--;
        end else if (bop == 8'h03) begin
          read_n++;
          for (int i = 0; i < ln; i++) rd[i*8 +: 8] = dev_mem[(fa + i) % 1024];
          if (read_n == corrupt_read_n) rd[0] = ~rd[0];
        end
        repeat (2) @(negedge clk);
        cmd_rdata = rd;
        cmd_ack = 1'b1;
        if (bop == 8'h02) wr_ack_cyc = cyc;
        @(negedge clk);
        cmd_ack = 1'b0;
      end
    end
  end

  task automatic clear_model();
    log_n = 0; busy_polls_cfg = 0; busy_left = 0; stuck_write_n = 0; write_n = 0;
    corrupt_read_n = 0; read_n = 0; stuck = 0;
    for (int i = 0; i < 1024; i++) dev_mem[i] = 8'hFF;
  endtask

  task automatic load_buf(int base);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = 6'(i); buf_wdata = 8'((i * 7 + base) & 255);
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic run_op(bit rd, int addr, int len, int ab, int sz, int blk);
    @(negedge clk);
    op_read = rd; start_addr = 24'(addr); xfer_len = 7'(len);
    cfg_addr_bytes = 2'(ab); cfg_size_log2 = 5'(sz); cfg_blk_log2 = 4'(blk);
    model_munge = (sz == 9) && (ab == 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    res_err = int'(err_code); res_cnt = int'(done_count);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cmd_req", int'(cmd_req), 0);
    chk("R1 err", int'(err_code), 0);
    chk("R1 count", int'(done_count), 0);
  endtask

  task automatic t_zero_len();
    clear_model();
    run_op(0, 16, 0, 2, 13, 5);
    chk("R11 err", res_err, 0);
    chk("R11 count", res_cnt, 0);
    chk("R11 no commands", log_n, 0);
  endtask

  task automatic t_write_blocks();
    int ea[4] = '{28, 32, 48, 64};
    int el[4] = '{4, 16, 16, 4};
    clear_model();
    load_buf(3);
    busy_polls_cfg = 1;
    run_op(0, 28, 40, 2, 13, 5);
    chk("R2 err", res_err, 0);
    chk("R2 count", res_cnt, 40);
    chk("R2 command total", log_n, 20);
    for (int k = 0; k < 4; k++) begin
      chk("R2 wren op", log_op[5*k], 8'h06);
      chk("R9 wren no addr", log_ab[5*k], 0);
      chk("R2 write op", log_op[5*k+1], 8'h02);
      chk("R3 write addr", log_addr[5*k+1], ea[k]);
      chk("R3 write len", log_len[5*k+1], el[k]);
      chk("R5 poll busy op", log_op[5*k+2], 8'h05);
      chk("R5 poll ready op", log_op[5*k+3], 8'h05);
      chk("R9 poll no addr", log_ab[5*k+2], 0);
      chk("R2 read op", log_op[5*k+4], 8'h03);
      chk("R2 read len", log_len[5*k+4], el[k]);
    end
    chk("R5 poll spacing", int'((log_cyc[3] - log_cyc[2]) >= PC && (log_cyc[3] - log_cyc[2]) <= PC + 5), 1);
    for (int i = 0; i < 40; i++) chk("R2 part content", int'(dev_mem[28 + i]), (i * 7 + 3) & 255);
  endtask

  task automatic t_poll_gap();
    clear_model();
    load_buf(9);
    run_op(0, 0, 4, 2, 13, 5);
    chk("R5 gap ack to poll", int'((log_cyc[2] - wr_ack_cyc) >= PC && (log_cyc[2] - wr_ack_cyc) <= PC + 2), 1);
    chk("R5 ready after one poll", log_n, 4);
  endtask

  task automatic t_munge(bit on);
    clear_model();
    load_buf(11);
    if (on) run_op(0, 252, 8, 1, 9, 3);
    else    run_op(0, 252, 8, 2, 13, 3);
    chk("R8 err", res_err, 0);
    chk("R8 first write op", log_op[1], 8'h02);
    chk("R8 second write op", log_op[5], on ? 8'h0A : 8'h02);
    chk("R8 second read op", log_op[7], on ? 8'h0B : 8'h03);
    chk("R9 second write addr", log_addr[5], on ? 0 : 256);
    chk("R9 addr bytes", log_ab[5], on ? 1 : 2);
    for (int i = 0; i < 4; i++) chk("R8 high page data", int'(dev_mem[256 + i]), ((i + 4) * 7 + 11) & 255);
  endtask

  task automatic t_timeout();
    int polls = 0;
    clear_model();
    load_buf(5);
    stuck_write_n = 2;
    run_op(0, 0, 20, 2, 13, 8);
    chk("R6 err timeout", res_err, 1);
    chk("R6 count", res_cnt, 16);
    for (int i = 6; i < log_n; i++) if (log_op[i] == 8'h05) polls++;
    chk("R6 poll count", polls, 50);
    chk("R6 last is poll", log_op[log_n-1], 8'h05);
  endtask

  task automatic t_mismatch();
    clear_model();
    load_buf(1);
    corrupt_read_n = 2;
    run_op(0, 0, 20, 2, 13, 8);
    chk("R7 err verify", res_err, 2);
    chk("R7 count", res_cnt, 16);
    chk("R7 stop after read", log_n, 8);
    chk("R7 last op", log_op[log_n-1], 8'h03);
    repeat (10) @(negedge clk);
    chk("R10 err held", int'(err_code), 2);
    chk("R10 count held", int'(done_count), 16);
    chk("R7 no later command", log_n, 8);
  endtask

  task automatic t_read();
    clear_model();
    for (int i = 0; i < 1024; i++) dev_mem[i] = 8'(i ^ 8'h5A);
    load_buf(0);
    run_op(1, 5, 20, 2, 13, 3);
    chk("R4 err", res_err, 0);
    chk("R4 count", res_cnt, 20);
    chk("R4 two reads only", log_n, 2);
    chk("R4 op", log_op[0], 8'h03);
    chk("R4 first len", log_len[0], 16);
    chk("R4 second addr", log_addr[1], 21);
    chk("R4 second len", log_len[1], 4);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      buf_addr = 6'(i);
      #1 chk("R4 buffer byte", int'(buf_rdata), (5 + i) ^ 8'h5A);
    end
    buf_addr = 6'(20);
    #1 chk("R4 beyond piece untouched", int'(buf_rdata), (20 * 7) & 255);
  endtask

  task automatic t_start_busy();
    clear_model();
    load_buf(2);
    @(negedge clk);
    op_read = 0; start_addr = 24'd0; xfer_len = 7'd8;
    cfg_addr_bytes = 2'd2; cfg_size_log2 = 5'd13; cfg_blk_log2 = 4'd8; model_munge = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    xfer_len = 7'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    chk("R10 restart ignored count", int'(done_count), 8);
    chk("R10 restart ignored err", int'(err_code), 0);
    @(negedge clk);
    chk("R10 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_read = 1'b0; start_addr = '0; xfer_len = '0;
    cfg_addr_bytes = 2'd2; cfg_size_log2 = 5'd13; cfg_blk_log2 = 4'd5;
    buf_we = 1'b0; buf_addr = '0; buf_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_write_blocks();
    t_poll_gap();
    t_munge(1'b1);
    t_munge(1'b0);
    t_timeout();
    t_mismatch();
    t_read();
    t_start_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule